// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block moves 8-bit channels between serial time-division streams. Streams come in pairs, an A stream and a B stream, on both the receive and the transmit side, and each pair runs at one of four bit rates in the ratio 1:2:4:8. A single master clock runs at the fastest bit rate. A frame pulse restarts the frame. Every receive stream is shifted in, most significant bit first, and each completed byte is written into one half of a two-bank data store. The banks swap at every frame pulse, so the transmit side always reads the complete previous frame.

Each transmit channel owns one entry in a connection store. When an entry's message flag is clear, it names a source stream and channel, and the transmitter sends that byte. When the flag is set, the entry's low byte goes out unchanged in every frame. A plain write/read host port fills the connection store. Host writes go into a shadow copy, and that copy is loaded into the live table at the next frame pulse. A frame is therefore always sent from one consistent table. Because each pair picks its rate on its own, a byte can arrive at one rate and leave at another.

Top module: `tdm_slot_switch`

## Requirements
- R1: The 2-bit rate code of group g sits at bits [2g+1:2g] of `rxRate` and `txRate`. Stream index 2g is stream A and 2g+1 is stream B of that group. Code c gives BASE_CH·2^c channels per frame, and each bit lasts 2^(3−c) clock cycles.
- R2: A clock edge that samples `fpIn` high restarts the frame. In the next cycle every stream is at bit 7 of channel 0, and the bits of each byte follow from bit 7 down to bit 0.
- R3: A connection entry with bit 8 clear routes a source. Entry bits [5:4] give the source stream index and bits [3:0] give the source channel (default parameters). Any transmit channel may name any receive channel, and many may name the same one.
- R4: A connection entry with bit 8 set sends its bits [7:0] in that transmit channel in every frame.
- R5: A routed entry whose source channel number is at or above the channel count of the source group's current rate sends 8'hFF.
- R6: The host address is {stream index, channel}. A write stores `hostWrData[8:0]`, and `hostRdData` returns the stored 9 bits with bits 15:9 at zero from the following cycle. A write changes the transmitted data only from the next frame pulse on.
- R7: A byte received in a frame is transmitted in the frame that follows the next frame pulse.
- R8: A byte received by a group at one rate is delivered correctly by a transmit group at a different rate.
- R9: After reset, all transmit outputs are high and every connection entry reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock, at the fastest stream rate |
| rstN | input | 1 | Asynchronous active-low reset |
| fpIn | input | 1 | Frame pulse, sampled on the clock edge that closes a frame |
| rxRate | input | 2*GROUPS | Rate code for each receive group |
| txRate | input | 2*GROUPS | Rate code for each transmit group |
| rxData | input | 2*GROUPS | Serial receive streams |
| txData | output | 2*GROUPS | Serial transmit streams |
| hostWe | input | 1 | Host write strobe for the connection store |
| hostAddr | input | log2(2*GROUPS)+log2(8*BASE_CH) | Host entry address {stream, channel} |
| hostWrData | input | 16 | Host write data; bits 8:0 are stored |
| hostRdData | output | 16 | Shadow entry at hostAddr, zero-extended |

## Verification
On every cycle, the assertions check the frame restart and the bank flip at each pulse, the hold of the bank between pulses, the host readback one cycle after a write, and the steadiness of a slow-rate transmit bit inside its bit period. Only the bench's scenarios can show that the right byte lands in the right channel. It does this through its reference model: it checks permutation routes at full rate, mixed receive and transmit rates with message entries and out-of-range sources, and a mid-frame host update whose effect must wait for the next pulse.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // Number of rate codes; rates step by a factor of two.
  localparam int RATE_CODES = 4;

  // Strobes from the frame controller to the datapath.
  typedef struct packed {
    logic                  swap;      // frame pulse seen this cycle
    logic                  wrBank;    // bank receiving the current frame
    logic [RATE_CODES-1:0] sampleStb; // last clock of a bit period, per rate
  } ctrl_t;

  // One connection store entry.
  typedef struct packed {
    logic       msg;      // 1: payload is a constant byte
    logic [7:0] payload;  // constant byte, or {stream, channel} of a source
  } cm_entry_t;

  localparam int CM_W = $bits(cm_entry_t);

endpackage

// File: rtl/tsi_frame_ctrl.sv
module tsi_frame_ctrl
  import tsi_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fpIn,
  output logic [CNT_W-1:0] cnt,
  output ctrl_t            ctrl
);

  logic bank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      bank <= 1'b0;
    end else if (fpIn) begin
      cnt  <= '0;
      bank <= ~bank;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ctrl.swap   = fpIn;
  assign ctrl.wrBank = bank;

  // A bit at rate code r lasts 2^(3-r) clocks; strobe on its last clock.
  for (genvar r = 0; r < RATE_CODES; r++) begin : g_stb
    if (r == RATE_CODES - 1) begin : g_full
      assign ctrl.sampleStb[r] = 1'b1;
    end else begin : g_part
      assign ctrl.sampleStb[r] = &cnt[RATE_CODES-2-r:0];
    end
  end

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter  int GROUPS  = 2,
  parameter  int BASE_CH = 2,
  localparam int NSTR    = 2 * GROUPS,
  localparam int MAXCH   = BASE_CH * 8,
  localparam int CHW     = $clog2(MAXCH),
  localparam int SW      = $clog2(NSTR),
  localparam int CNT_W   = CHW + 3,
  localparam int ADDR_W  = SW + CHW,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cnt,
  input  ctrl_t             ctrl,
  input  logic [NSTR-1:0]   rxData,
  input  logic [2*GROUPS-1:0] rxRate,
  input  logic [2*GROUPS-1:0] txRate,
  output logic [NSTR-1:0]   txData,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  cm_entry_t         hostEntry,
  output cm_entry_t         hostEntryRd
);

  // Bit position within the byte (0 = first, MSB) at a rate code.
  function automatic logic [2:0] bitOf(input logic [CNT_W-1:0] c, input logic [1:0] r);
    return 3'(c >> (2'd3 - r));
  endfunction

  // Channel number within the frame at a rate code.
  function automatic logic [CHW-1:0] chanOf(input logic [CNT_W-1:0] c, input logic [1:0] r);
    return CHW'(c >> (3'd6 - {1'b0, r}));
  endfunction

  logic [1:0] inRate [NSTR];
  logic [1:0] outRate[NSTR];

  for (genvar s = 0; s < NSTR; s++) begin : g_rate
    assign inRate[s]  = rxRate[2*(s/2) +: 2];
    assign outRate[s] = txRate[2*(s/2) +: 2];
  end

  // Receive shifters and two-bank data store.
  logic [6:0] shReg[NSTR];
  logic [7:0] dataMem[2][DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++)
          dataMem[b][i] <= 8'hFF;
      for (int s = 0; s < NSTR; s++)
        shReg[s] <= '0;
    end else begin
      for (int s = 0; s < NSTR; s++) begin
        if (ctrl.sampleStb[inRate[s]]) begin
          shReg[s] <= {shReg[s][5:0], rxData[s]};
          if (bitOf(cnt, inRate[s]) == 3'd7)
            dataMem[ctrl.wrBank][{SW'(s), chanOf(cnt, inRate[s])}] <= {shReg[s], rxData[s]};
        end
      end
    end
  end

  // Connection store: host shadow plus live copy loaded at each frame pulse.
  cm_entry_t cmHost[DEPTH];
  cm_entry_t cmLive[DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cmHost[i] <= '0;
        cmLive[i] <= '0;
      end
    end else begin
      if (ctrl.swap) cmLive <= cmHost;
      if (hostWe) cmHost[hostAddr] <= hostEntry;
    end
  end

  assign hostEntryRd = cmHost[hostAddr];

  // Transmit selection, one per output stream.
  for (genvar o = 0; o < NSTR; o++) begin : g_tx
    logic [CHW-1:0] outCh;
    logic [2:0]     outBit;
    cm_entry_t      ent;
    logic [SW-1:0]  srcStr;
    logic [CHW-1:0] srcCh;
    logic           srcLive;
    logic [7:0]     outByte;

    always_comb begin
      outCh   = chanOf(cnt, outRate[o]);
      outBit  = bitOf(cnt, outRate[o]);
      ent     = cmLive[{SW'(o), outCh}];
      srcStr  = ent.payload[SW+CHW-1:CHW];
      srcCh   = ent.payload[CHW-1:0];
      srcLive = int'(srcCh) < (BASE_CH << inRate[srcStr]);
      if (ent.msg)       outByte = ent.payload;
      else if (!srcLive) outByte = 8'hFF;
      else               outByte = dataMem[!ctrl.wrBank][{srcStr, srcCh}];
    end

    assign txData[o] = outByte[3'd7 - outBit];
  end

endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch
  import tsi_pkg::*;
#(
  parameter  int GROUPS  = 2,
  parameter  int BASE_CH = 2,
  localparam int NSTR    = 2 * GROUPS,
  localparam int CHW     = $clog2(BASE_CH * 8),
  localparam int ADDR_W  = $clog2(NSTR) + CHW,
  localparam int CNT_W   = CHW + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fpIn,
  input  logic [2*GROUPS-1:0] rxRate,
  input  logic [2*GROUPS-1:0] txRate,
  input  logic [NSTR-1:0]     rxData,
  output logic [NSTR-1:0]     txData,
  input  logic                hostWe,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [15:0]         hostWrData,
  output logic [15:0]         hostRdData
);

  logic [CNT_W-1:0] frameCnt;
  ctrl_t            ctrlS;
  cm_entry_t        entryRd;
  logic             unusedHostHi;

  assign unusedHostHi = ^hostWrData[15:CM_W];

  tsi_frame_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk (clk),
    .rstN(rstN),
    .fpIn(fpIn),
    .cnt (frameCnt),
    .ctrl(ctrlS)
  );

  tsi_datapath #(.GROUPS(GROUPS), .BASE_CH(BASE_CH)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cnt        (frameCnt),
    .ctrl       (ctrlS),
    .rxData     (rxData),
    .rxRate     (rxRate),
    .txRate     (txRate),
    .txData     (txData),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostEntry  (cm_entry_t'(hostWrData[CM_W-1:0])),
    .hostEntryRd(entryRd)
  );

  assign hostRdData = {{(16-CM_W){1'b0}}, entryRd};

endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 6,
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fpIn,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrBank,
  input logic [1:0]        txRate0,
  input logic [RATE_W-1:0] rxRate,
  input logic              tx0,
  input logic              hostWe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [8:0]        hostWrLow,
  input logic [15:0]       hostRdData
);

  // R2: frame pulse restarts the bit counter
  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    fpIn |=> (cnt == '0));

  // R7: banks flip at every frame pulse
  assert_bank_swap_R7: assert property (@(posedge clk) disable iff (!rstN)
    fpIn |=> (wrBank != $past(wrBank)));

  // R7: banks hold between pulses
  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !fpIn |=> (wrBank == $past(wrBank)));

  // R6: written entry visible one cycle later at the same address
  assert_readback_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostWe |=> ((hostAddr != $past(hostAddr)) ||
                (hostRdData == {7'b0, $past(hostWrLow)})));

  // R1: at the slowest rate a bit stays put for its whole period
  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txRate0 == 2'd0 && cnt[2:0] != 3'd0 && $stable(txRate0) && $stable(rxRate))
      |-> $stable(tx0));

endmodule

bind tdm_slot_switch tsi_checker #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W),
  .RATE_W(2*GROUPS)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .fpIn      (fpIn),
  .cnt       (frameCnt),
  .wrBank    (ctrlS.wrBank),
  .txRate0   (txRate[1:0]),
  .rxRate    (rxRate),
  .tx0       (txData[0]),
  .hostWe    (hostWe),
  .hostAddr  (hostAddr),
  .hostWrLow (hostWrData[8:0]),
  .hostRdData(hostRdData)
);

// File: tb/test_tdm_slot_switch.sv
module test_tdm_slot_switch;

  localparam int GROUPS    = 2;
  localparam int BASE_CH   = 2;
  localparam int NSTR      = 2 * GROUPS;
  localparam int MAXCH     = BASE_CH * 8;
  localparam int FRAME_LEN = MAXCH * 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fpIn = 1'b0;
  logic [3:0]  rxRate = '0;
  logic [3:0]  txRate = '0;
  logic [3:0]  rxData = '0;
  logic [3:0]  txData;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;

  always #10 clk = ~clk;

  tdm_slot_switch #(.GROUPS(GROUPS), .BASE_CH(BASE_CH)) i_tdm_slot_switch (
    .clk(clk), .rstN(rstN), .fpIn(fpIn), .rxRate(rxRate), .txRate(txRate),
    .rxData(rxData), .txData(txData), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  typedef struct packed {
    logic [7:0] val;
    logic [7:0] req;
  } exp_t;

  exp_t       expQ[NSTR][$];
  logic [8:0] shadowM[64];
  logic [8:0] activeM[64];
  int  checks = 0, fails = 0;
  int  curCnt = 0, frameNo = 0, monCnt = 0, plainReq = 3;
  bit  checkOn = 0, monOn = 0, ended = 0;

  function automatic logic [7:0] pat(int f, int s, int ch);
    return 8'((f * 37 + s * 53 + ch * 11 + 7) ^ (ch * 16));
  endfunction

  function automatic int chans(logic [1:0] r);
    return BASE_CH << r;
  endfunction

  task automatic check(bit ok, int req, string what, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Driver side of the scoreboard: expected bytes for the frame now starting.
  task automatic pushFrame();
    for (int o = 0; o < NSTR; o++) begin
      logic [1:0] ro;
      ro = txRate[2*(o/2) +: 2];
      for (int k = 0; k < chans(ro); k++) begin
        logic [8:0] e;
        exp_t x;
        int src, sch;
        logic [1:0] ri;
        e   = activeM[o*MAXCH + k];
        src = int'(e[5:4]);
        sch = int'(e[3:0]);
        ri  = rxRate[2*(src/2) +: 2];
        if (e[8]) begin
          x.val = e[7:0]; x.req = 8'd4;                 // R4 message byte
        end else if (sch >= chans(ri)) begin
          x.val = 8'hFF; x.req = 8'd5;                   // R5 missing source
        end else begin
          x.val = pat(frameNo - 1, src, sch);            // R7 previous frame
          x.req = (ri != ro) ? 8'd8 : 8'(plainReq);      // R8 rate conversion
        end
        expQ[o].push_back(x);
      end
    end
  endtask

  // One clock of stimulus, driven at the falling edge.
  task automatic tick(bit we, logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    monCnt = curCnt;
    if (curCnt == 0 && checkOn) pushFrame();
    for (int s = 0; s < NSTR; s++) begin
      logic [1:0] r;
      logic [7:0] b;
      int ch, bi;
      r  = rxRate[2*(s/2) +: 2];
      ch = curCnt >> (6 - r);
      bi = (curCnt >> (3 - r)) & 7;
      b  = pat(frameNo, s, ch);
      rxData[s] = b[7 - bi];                             // R2 MSB first
    end
    fpIn       = (curCnt == FRAME_LEN - 1);
    hostWe     = we;
    hostAddr   = a;
    hostWrData = d;
    if (curCnt == FRAME_LEN - 1) activeM = shadowM;      // R6 copy at pulse
    if (we) shadowM[a] = d[8:0];
    curCnt++;
    if (curCnt == FRAME_LEN) begin
      curCnt = 0;
      frameNo++;
    end
  endtask

  task automatic runUntil(int c);
    do tick(1'b0, '0, '0); while (curCnt != c);
  endtask

  task automatic setRoute(int o, int k, logic [8:0] e);
    tick(1'b1, 6'(o*MAXCH + k), {7'b0, e});
  endtask

  task automatic drainCheck();
    #5;
    for (int o = 0; o < NSTR; o++) begin
      check(expQ[o].size() == 0, 3, "bytes left unsent", 16'(expQ[o].size()), 16'd0);
      expQ[o].delete();
    end
  endtask

  // Monitor side of the scoreboard.
  initial begin
    logic [7:0] acc[NSTR];
    for (int o = 0; o < NSTR; o++) acc[o] = '0;
    forever begin
      @(negedge clk);
      #2;
      if (monOn) begin
        for (int o = 0; o < NSTR; o++) begin
          logic [1:0] r;
          int p;
          r = txRate[2*(o/2) +: 2];
          p = 8 >> r;
          if ((monCnt % p) == p - 1) begin
            acc[o] = {acc[o][6:0], txData[o]};
            if (((monCnt >> (3 - r)) & 7) == 7 && expQ[o].size() > 0) begin
              exp_t x;
              x = expQ[o].pop_front();
              check(acc[o] == x.val, int'(x.req), $sformatf("stream %0d byte", o),
                    16'(acc[o]), 16'(x.val));
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", checks, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      shadowM[i] = '0;
      activeM[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    // R9: reset state
    check(txData == 4'hF, 9, "tx after reset", 16'(txData), 16'hF);
    check(hostRdData == 16'h0, 9, "entry 0 after reset", hostRdData, 16'h0);
    monOn = 1;
    runUntil(0);

    // Scenario 1: full rate everywhere, permutation routes (R3, R7, R2, R1)
    rxRate = 4'hF; txRate = 4'hF; plainReq = 7;
    for (int o = 0; o < NSTR; o++)
      for (int k = 0; k < MAXCH; k++)
        setRoute(o, k, {1'b0, 2'((o + 1) % 4), 4'((k * 7 + 3) % 16)});
    runUntil(0);
    checkOn = 1;
    runUntil(FRAME_LEN - 1); runUntil(0);
    runUntil(FRAME_LEN - 1); checkOn = 0; runUntil(0);
    drainCheck();

    // Scenario 2: mixed rates, messages and missing sources (R1, R4, R5, R8)
    rxRate = 4'b1000; txRate = 4'b1011; plainReq = 1;
    for (int o = 0; o < NSTR; o++)
      for (int k = 0; k < MAXCH; k++) begin
        if (k % 4 == 0) setRoute(o, k, {1'b1, 8'(8'hA0 + o*16 + k)});
        else            setRoute(o, k, {1'b0, 2'((k + o) % 4), 4'((k * 3) % 16)});
      end
    runUntil(0);
    checkOn = 1;
    runUntil(FRAME_LEN - 1); runUntil(0);
    runUntil(FRAME_LEN - 1); checkOn = 0; runUntil(0);
    drainCheck();

    // Scenario 3: mid-frame host update waits for the next pulse (R6, R3)
    rxRate = 4'b0101; txRate = 4'b0101; plainReq = 3;
    for (int o = 0; o < NSTR; o++)
      for (int k = 0; k < 4; k++)
        setRoute(o, k, {1'b0, 2'(3 - o), 4'(k)});
    runUntil(0);
    checkOn = 1;
    runUntil(40);
    setRoute(0, 1, 9'h13C);
    tick(1'b0, 6'd1, '0);
    #1 check(hostRdData == 16'h013C, 6, "readback message entry", hostRdData, 16'h013C);
    tick(1'b1, 6'd2, 16'hFE55);
    tick(1'b0, 6'd2, '0);
    #1 check(hostRdData == 16'h0055, 6, "readback masks upper bits", hostRdData, 16'h0055);
    runUntil(0);
    runUntil(FRAME_LEN - 1); checkOn = 0; runUntil(0);
    drainCheck();

    finishRun();
  end

endmodule